// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the storage and arithmetic half of a multicycle 32-bit load/store processor. It holds the program counter, the instruction register, the memory data register, two operand registers, the ALU result register, a 32-entry register file, the ALU and a small unified word-addressed memory. The block makes no decisions of its own. An external sequencer drives a set of per-cycle strobes and select codes, and it reads back the opcode, the function code and a zero flag to choose its next step.

Every instruction passes through a fetch step, which reads memory at the PC, latches the instruction and advances the PC by four. A decode step follows, which reads both source registers and precomputes the branch target into the ALU result register. One to three further steps complete the instruction. Branch equality is tested by XOR-ing the two operands and sampling the zero flag. A link step for jump-and-link can write the PC into register 31 in the same cycle that the PC takes the jump address. An initialisation write port lets the surrounding logic place words in memory before the sequencer starts.

Top module: `mc_datapath`

## Requirements
- R1: After reset the PC, the instruction register, the memory data register, the operand registers, the ALU result register, every register-file entry and every memory word are zero.
- R2: The memory word index is byte-address bits [MAW+1:2], where MAW = log2(MEM_WORDS). The byte address is the PC when `mem_addr_sel` is 0 and the ALU result register when it is 1. `mem_rdata` shows the addressed word while `mem_rd` is 1 and is zero otherwise. When `mem_wr` is 1, the operand-B register is written to the addressed word at the clock edge.
- R3: The PC loads only on an edge where `pc_update` is 1. `pc_sel` picks the next PC: 0 is the live ALU result, 1 is the ALU result register, 2 is {PC[31:28], IR[25:0], 2'b00}, and 3 keeps the PC.
- R4: The instruction register loads `mem_rdata` only on an edge where `ir_load` is 1. `opcode` is IR[31:26] and `funct` is IR[5:0].
- R5: ALU input A is the operand-A register when `alu_a_sel` is 0 and the PC when it is 1. ALU input B is picked by `alu_b_sel`: 0 is the operand-B register, 1 is the constant 4, 2 is IR[15:0] sign-extended, and 3 is that sign-extended value shifted left by two.
- R6: `alu_op` codes are 0 add, 1 subtract (A−B), 2 AND, 3 OR, 4 XOR, 5 A shifted left by B[4:0], 6 A shifted right logically by B[4:0], and 7 a zero result. `zero` is 1 exactly when `alu_result` is all zeros.
- R7: On an edge where `reg_we` is 1, the register file writes one entry. `wdata_sel` picks the data: 0 is the ALU result register, 1 is the memory data register, and 2 is the PC. `waddr_sel` picks the entry: 0 is IR[20:16], 1 is IR[15:11], and 2 is entry 31.
- R8: Register-file entry 0 always reads as zero, and writes to it have no effect.
- R9: On every clock edge the operand-A register loads the entry at IR[25:21], the operand-B register loads the entry at IR[20:16], the memory data register loads `mem_rdata`, and the ALU result register loads `alu_result`.
- R10: When `init_we` is 1, `init_data` is written to memory word `init_addr` at the clock edge. This write takes priority over a `mem_wr` write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_update | input | 1 | PC load enable |
| ir_load | input | 1 | Instruction register load enable |
| mem_addr_sel | input | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable (data from operand-B register) |
| reg_we | input | 1 | Register-file write enable |
| wdata_sel | input | 2 | Register write data select |
| waddr_sel | input | 2 | Register write address select |
| alu_a_sel | input | 1 | ALU input A select |
| alu_b_sel | input | 2 | ALU input B select |
| alu_op | input | 3 | ALU operation code |
| pc_sel | input | 2 | Next-PC select |
| init_we | input | 1 | Memory initialisation write enable |
| init_addr | input | MAW | Memory initialisation word index |
| init_data | input | XLEN | Memory initialisation data |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | ALU result is zero |
| pc | output | XLEN | Current program counter |
| alu_result | output | XLEN | Live ALU result |
| mem_rdata | output | XLEN | Memory read data |

## Verification
Three outputs are combinational from the registers and the current strobes: `alu_result`, `zero` and `mem_rdata`. The bench therefore checks them one time unit after it drives a step's controls, inside the same cycle. `pc`, `opcode` and `funct` change only at the edge that closes a step, so they are checked on the falling edge after it. A register-file write becomes visible one step later at the earliest. It is checked through the ALU result two edges after the write: the next decode edge loads the operand registers, and the following execute step combines them. A load is checked twice. `mem_rdata` is checked during the memory step, and the loaded register is checked through the ALU two steps after the write-back edge.

// File: rtl/dp_pkg.sv
package dp_pkg;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_XOR = 3'd4,
      ALU_SLL = 3'd5,
      ALU_SRL = 3'd6,
      ALU_NUL = 3'd7
   } alu_op_e;

   localparam logic [1:0] WD_ALUQ = 2'd0;
   localparam logic [1:0] WD_MDR  = 2'd1;
   localparam logic [1:0] WD_PC   = 2'd2;

   localparam logic [1:0] WA_RT   = 2'd0;
   localparam logic [1:0] WA_RD   = 2'd1;
   localparam logic [1:0] WA_LINK = 2'd2;

   localparam logic [1:0] PB_REG  = 2'd0;
   localparam logic [1:0] PB_FOUR = 2'd1;
   localparam logic [1:0] PB_IMM  = 2'd2;
   localparam logic [1:0] PB_OFS  = 2'd3;

   localparam logic [1:0] NP_LIVE = 2'd0;
   localparam logic [1:0] NP_REG  = 2'd1;
   localparam logic [1:0] NP_JUMP = 2'd2;

endpackage

// File: rtl/dp_alu.sv
module dp_alu
   import dp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [2:0]      op_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] y_o,
   output logic            zero_o
);

   localparam int SHW = $clog2(XLEN);

   logic [SHW-1:0] shamt;
   assign shamt = b_i[SHW-1:0];

   always_comb begin
      case (alu_op_e'(op_i))
         ALU_ADD: y_o = a_i + b_i;
         ALU_SUB: y_o = a_i - b_i;
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         ALU_XOR: y_o = a_i ^ b_i;
         ALU_SLL: y_o = a_i << shamt;
         ALU_SRL: y_o = a_i >> shamt;
         default: y_o = '0;
      endcase
   end

   assign zero_o = ~|y_o;

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [$clog2(NREGS)-1:0] waddr_i,
   input  logic [XLEN-1:0]          wdata_i,
   input  logic [$clog2(NREGS)-1:0] raddr_a_i,
   input  logic [$clog2(NREGS)-1:0] raddr_b_i,
   output logic [XLEN-1:0]          rdata_a_o,
   output logic [XLEN-1:0]          rdata_b_o
);

   logic [XLEN-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_entry
      if (g == 0) begin : g_hardzero
         assign regs[g] = '0;
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[g] <= '0;
            end else if (we_i && (int'(waddr_i) == g)) begin
               regs[g] <= wdata_i;
            end
         end
      end
   end

   assign rdata_a_o = regs[raddr_a_i];
   assign rdata_b_o = regs[raddr_b_i];

endmodule

// File: rtl/dp_memory.sv
module dp_memory #(
   parameter int XLEN  = 32,
   parameter int WORDS = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(WORDS)-1:0] idx_i,
   input  logic                     rd_i,
   input  logic                     wr_i,
   input  logic [XLEN-1:0]          wdata_i,
   input  logic                     init_we_i,
   input  logic [$clog2(WORDS)-1:0] init_idx_i,
   input  logic [XLEN-1:0]          init_data_i,
   output logic [XLEN-1:0]          rdata_o
);

   logic [XLEN-1:0] cells [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells[g] <= '0;
         end else if (init_we_i) begin
            if (int'(init_idx_i) == g) cells[g] <= init_data_i;
         end else if (wr_i && (int'(idx_i) == g)) begin
            cells[g] <= wdata_i;
         end
      end
   end

   assign rdata_o = rd_i ? cells[idx_i] : '0;

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import dp_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int MEM_WORDS = 64,
   parameter int MAW       = $clog2(MEM_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pc_update,
   input  logic            ir_load,
   input  logic            mem_addr_sel,
   input  logic            mem_rd,
   input  logic            mem_wr,
   input  logic            reg_we,
   input  logic [1:0]      wdata_sel,
   input  logic [1:0]      waddr_sel,
   input  logic            alu_a_sel,
   input  logic [1:0]      alu_b_sel,
   input  logic [2:0]      alu_op,
   input  logic [1:0]      pc_sel,
   input  logic            init_we,
   input  logic [MAW-1:0]  init_addr,
   input  logic [XLEN-1:0] init_data,
   output logic [5:0]      opcode,
   output logic [5:0]      funct,
   output logic            zero,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] alu_result,
   output logic [XLEN-1:0] mem_rdata
);

   localparam int NREGS   = 32;
   localparam int RAW     = $clog2(NREGS);
   localparam int IMMW    = 16;
   localparam int JTW     = 26;
   localparam int LINKREG = NREGS - 1;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mc_datapath: instruction fields require XLEN of 32");
   end
   if (MEM_WORDS < 2 || (MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_mem
      $error("mc_datapath: MEM_WORDS must be a power of two of at least 2");
   end
   if (MAW != $clog2(MEM_WORDS)) begin : g_bad_maw
      $error("mc_datapath: MAW must equal log2 of MEM_WORDS");
   end

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
   logic [XLEN-1:0] rf_a, rf_b, rf_wdata, src_a, src_b, imm_ext, ofs_ext;
   logic [XLEN-1:0] jump_tgt, pc_next, alu_y;
   logic [RAW-1:0]  rf_waddr;
   logic [MAW-1:0]  mem_idx;
   logic            alu_z;

   // instruction field extraction
   assign imm_ext  = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
   assign ofs_ext  = {imm_ext[XLEN-3:0], 2'b00};
   assign jump_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[JTW-1:0], 2'b00};

   // memory address steering (word index only)
   assign mem_idx = mem_addr_sel ? aluout_q[MAW+1:2] : pc_q[MAW+1:2];

   // ALU operand steering
   assign src_a = alu_a_sel ? pc_q : a_q;

   always_comb begin
      case (alu_b_sel)
         PB_REG:  src_b = b_q;
         PB_FOUR: src_b = XLEN'(4);
         PB_IMM:  src_b = imm_ext;
         default: src_b = ofs_ext;
      endcase
   end

   // register-file write steering
   always_comb begin
      case (wdata_sel)
         WD_MDR:  rf_wdata = mdr_q;
         WD_PC:   rf_wdata = pc_q;
         default: rf_wdata = aluout_q;
      endcase
   end

   always_comb begin
      case (waddr_sel)
         WA_RD:   rf_waddr = ir_q[15:11];
         WA_LINK: rf_waddr = RAW'(LINKREG);
         default: rf_waddr = ir_q[20:16];
      endcase
   end

   // next-PC steering
   always_comb begin
      case (pc_sel)
         NP_LIVE: pc_next = alu_y;
         NP_REG:  pc_next = aluout_q;
         NP_JUMP: pc_next = jump_tgt;
         default: pc_next = pc_q;
      endcase
   end

   dp_regfile #(
      .XLEN  (XLEN),
      .NREGS (NREGS)
   ) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (reg_we),
      .waddr_i   (rf_waddr),
      .wdata_i   (rf_wdata),
      .raddr_a_i (ir_q[25:21]),
      .raddr_b_i (ir_q[20:16]),
      .rdata_a_o (rf_a),
      .rdata_b_o (rf_b)
   );

   dp_alu #(
      .XLEN (XLEN)
   ) u_alu (
      .op_i   (alu_op),
      .a_i    (src_a),
      .b_i    (src_b),
      .y_o    (alu_y),
      .zero_o (alu_z)
   );

   dp_memory #(
      .XLEN  (XLEN),
      .WORDS (MEM_WORDS)
   ) u_mem (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx_i       (mem_idx),
      .rd_i        (mem_rd),
      .wr_i        (mem_wr),
      .wdata_i     (b_q),
      .init_we_i   (init_we),
      .init_idx_i  (init_addr),
      .init_data_i (init_data),
      .rdata_o     (mem_rdata)
   );

   // architectural and pipeline-step registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         ir_q     <= '0;
         mdr_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
      end else begin
         if (pc_update) pc_q <= pc_next;
         if (ir_load)   ir_q <= mem_rdata;
         mdr_q    <= mem_rdata;
         a_q      <= rf_a;
         b_q      <= rf_b;
         aluout_q <= alu_y;
      end
   end

   assign opcode     = ir_q[31:26];
   assign funct      = ir_q[5:0];
   assign zero       = alu_z;
   assign pc         = pc_q;
   assign alu_result = alu_y;

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pc_update,
   input logic            ir_load,
   input logic [1:0]      pc_sel,
   input logic            alu_a_sel,
   input logic [1:0]      alu_b_sel,
   input logic [2:0]      alu_op,
   input logic            zero,
   input logic [XLEN-1:0] pc_q,
   input logic [XLEN-1:0] ir_q,
   input logic [XLEN-1:0] a_q,
   input logic [XLEN-1:0] b_q
);

   assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_update |=> $stable(pc_q));

   assert_jump_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_update && pc_sel == 2'd2) |=>
         (pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4])) && (pc_q[1:0] == 2'b00));

   assert_ir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_load |=> $stable(ir_q));

   assert_fetch_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_update && pc_sel == 2'd0 && alu_a_sel && alu_b_sel == 2'd1 && alu_op == 3'd0)
         |=> pc_q == $past(pc_q) + XLEN'(4));

   assert_xor_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_op == 3'd4 && !alu_a_sel && alu_b_sel == 2'd0) |-> zero == (a_q == b_q));

   assert_reg0_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ir_q[25:21]) == 5'd0) |-> a_q == '0);

endmodule

bind mc_datapath dp_checker #(.XLEN(XLEN)) u_dp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc_update (pc_update),
   .ir_load   (ir_load),
   .pc_sel    (pc_sel),
   .alu_a_sel (alu_a_sel),
   .alu_b_sel (alu_b_sel),
   .alu_op    (alu_op),
   .zero      (zero),
   .pc_q      (pc_q),
   .ir_q      (ir_q),
   .a_q       (a_q),
   .b_q       (b_q)
);

// File: tb/test_mc_datapath.sv
module test_mc_datapath;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32;
   localparam int MEM_WORDS = 64;
   localparam int MAW = 6;

   logic            clk, rst_n;
   logic            pc_update, ir_load, mem_addr_sel, mem_rd, mem_wr, reg_we;
   logic [1:0]      wdata_sel, waddr_sel, alu_b_sel, pc_sel;
   logic            alu_a_sel;
   logic [2:0]      alu_op;
   logic            init_we;
   logic [MAW-1:0]  init_addr;
   logic [XLEN-1:0] init_data;
   logic [5:0]      opcode, funct;
   logic            zero;
   logic [XLEN-1:0] pc, alu_result, mem_rdata;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [31:0] rf_m [32];
   logic [31:0] exp_pc;

   mc_datapath #(.XLEN(XLEN), .MEM_WORDS(MEM_WORDS)) i_mc_datapath (
      .clk(clk), .rst_n(rst_n), .pc_update(pc_update), .ir_load(ir_load),
      .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_we(reg_we),
      .wdata_sel(wdata_sel), .waddr_sel(waddr_sel), .alu_a_sel(alu_a_sel),
      .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_sel(pc_sel), .init_we(init_we),
      .init_addr(init_addr), .init_data(init_data), .opcode(opcode), .funct(funct),
      .zero(zero), .pc(pc), .alu_result(alu_result), .mem_rdata(mem_rdata)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   function automatic logic [31:0] alu_m(input int op, input logic [31:0] a, input logic [31:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return a & b;
         3: return a | b;
         4: return a ^ b;
         5: return a << b[4:0];
         6: return a >> b[4:0];
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] sx(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic idle();
      pc_update = 0; ir_load = 0; mem_addr_sel = 0; mem_rd = 0; mem_wr = 0; reg_we = 0;
      wdata_sel = 0; waddr_sel = 0; alu_a_sel = 0; alu_b_sel = 0; alu_op = 0; pc_sel = 0;
      init_we = 0; init_addr = 0; init_data = 0;
   endtask

   // place a word in memory through the initialisation port, then fetch and decode it
   task automatic fetch_decode(input logic [31:0] word);
      idle();
      init_we = 1; init_addr = exp_pc[7:2]; init_data = word;
      @(negedge clk);
      idle();
      mem_rd = 1; ir_load = 1; alu_a_sel = 1; alu_b_sel = 1; pc_sel = 0; pc_update = 1;
      #1;
      chk("R10 init word read back at PC (R2)", mem_rdata, word);
      chk("R5 PC plus four on ALU", alu_result, exp_pc + 32'd4);
      @(negedge clk);
      exp_pc = exp_pc + 32'd4;
      chk("R3 PC after fetch", pc, exp_pc);
      chk("R4 opcode field", {26'd0, opcode}, {26'd0, word[31:26]});
      chk("R4 funct field", {26'd0, funct}, {26'd0, word[5:0]});
      idle();
      alu_a_sel = 1; alu_b_sel = 3;
      #1;
      chk("R5 branch target on ALU", alu_result, exp_pc + {sx(word[15:0]), 2'b00} - {sx(word[15:0]), 2'b00} + {sx(word[15:0])} * 4);
      chk("R2 read data zero while not reading", mem_rdata, 32'd0);
      @(negedge clk);
      chk("R3 PC holds without update", pc, exp_pc);
   endtask

   task automatic run_addi(input int rt, input int rs, input logic [15:0] imm);
      logic [31:0] w;
      w = enc_i(6'h08, rs, rt, imm);
      fetch_decode(w);
      idle();
      alu_b_sel = 2;
      #1;
      chk("R5 R9 register plus sign-extended immediate", alu_result, rf_m[rs] + sx(imm));
      @(negedge clk);
      idle();
      reg_we = 1; wdata_sel = 0; waddr_sel = 0;
      @(negedge clk);
      if (rt != 0) rf_m[rt] = rf_m[rs] + sx(imm);
      chk("R4 IR held through execute", {26'd0, opcode}, 32'h08);
   endtask

   // execute step sweeps every ALU code, then finishes with wop and writes rd
   task automatic run_r(input int rs, input int rt, input int rd, input int wop, input string tag);
      logic [31:0] a, b, res;
      fetch_decode(enc_r(rs, rt, rd, 6'h20));
      a = rf_m[rs];
      b = rf_m[rt];
      for (int op = 0; op < 9; op++) begin
         idle();
         alu_op = 3'((op == 8) ? wop : op);
         #1;
         res = alu_m((op == 8) ? wop : op, a, b);
         chk({"R6 ", tag, " result"}, alu_result, res);
         chk({"R6 ", tag, " zero flag"}, {31'd0, zero}, {31'd0, (res == 32'd0)});
         @(negedge clk);
      end
      idle();
      reg_we = 1; wdata_sel = 0; waddr_sel = 1;
      @(negedge clk);
      if (rd != 0) rf_m[rd] = alu_m(wop, a, b);
   endtask

   task automatic run_mem(input bit is_load, input int rt, input int rs, input logic [15:0] off,
                          input logic [31:0] expv);
      fetch_decode(enc_i(is_load ? 6'h23 : 6'h2b, rs, rt, off));
      idle();
      alu_b_sel = 2;
      @(negedge clk);
      idle();
      mem_addr_sel = 1;
      if (is_load) begin
         mem_rd = 1;
         #1;
         chk("R2 load reads ALU-register address", mem_rdata, expv);
      end else begin
         mem_wr = 1;
      end
      @(negedge clk);
      if (is_load) begin
         idle();
         reg_we = 1; wdata_sel = 1; waddr_sel = 0;
         @(negedge clk);
         if (rt != 0) rf_m[rt] = expv;
      end
   endtask

   task automatic run_beq(input int rs, input int rt, input logic [15:0] off, input bit taken);
      fetch_decode(enc_i(6'h04, rs, rt, off));
      idle();
      alu_op = 3'd4; pc_sel = 1;
      #1;
      chk("R6 equality by XOR zero flag", {31'd0, zero}, {31'd0, taken});
      pc_update = zero;
      @(negedge clk);
      if (taken) exp_pc = exp_pc + {sx(off)[29:0], 2'b00};
      chk("R3 branch PC from ALU register", pc, exp_pc);
   endtask

   task automatic run_jal(input logic [25:0] tgt);
      fetch_decode({6'h03, tgt});
      idle();
      pc_sel = 2; pc_update = 1; reg_we = 1; wdata_sel = 2; waddr_sel = 2;
      @(negedge clk);
      rf_m[31] = exp_pc;
      exp_pc = {exp_pc[31:28], tgt, 2'b00};
      chk("R3 jump address", pc, exp_pc);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) rf_m[i] = 32'd0;
      exp_pc = 32'd0;
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      mem_rd = 1;
      #1;
      chk("R1 PC after reset", pc, 32'd0);
      chk("R1 opcode after reset", {26'd0, opcode}, 32'd0);
      chk("R1 funct after reset", {26'd0, funct}, 32'd0);
      chk("R1 ALU over zero registers", alu_result, 32'd0);
      chk("R1 zero flag after reset", {31'd0, zero}, 32'd1);
      chk("R1 memory word zero after reset", mem_rdata, 32'd0);
      @(negedge clk);

      run_addi(1, 0, 16'h1234);
      run_addi(2, 0, 16'hFFFD);
      run_r(1, 2, 3, 0, "R9 mixed-sign pair");
      run_addi(4, 0, 16'h7FFF);
      run_r(4, 4, 5, 1, "equal pair");
      run_addi(8, 0, 16'h8000);
      run_r(4, 8, 9, 4, "sign boundary pair");
      run_r(3, 9, 6, 3, "R7 rd destination");
      run_addi(0, 0, 16'h0005);
      run_r(0, 0, 0, 3, "R8 entry zero after write");
      run_mem(0, 1, 0, 16'd200, 32'd0);
      run_mem(1, 7, 0, 16'd200, 32'h0000_1234);
      run_r(7, 0, 0, 3, "R7 loaded value");
      run_beq(1, 7, 16'd2, 1'b1);
      run_beq(1, 2, 16'hFFF0, 1'b0);
      run_jal(26'd40);
      run_r(31, 0, 0, 3, "R7 link register");

      summary();
   end

endmodule